// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This core executes programs held in a single word-addressed memory, one instruction at a time. Each instruction passes through a fixed phase sequence: the word at the program counter is fetched into an instruction register, the operand is resolved, and the result is applied to the accumulator, to memory or to the program counter. All arithmetic is performed on one accumulator register. There are no status flags. A compare instruction instead steps the program counter over the following instruction when its operand matches the accumulator.

The memory port is synchronous with one cycle of read latency. The core therefore inserts a wait phase whenever an instruction takes its operand from memory. Peripherals are reached the same way as data, through loads and stores to chosen addresses. Once a stop instruction executes, the core raises `halted`, fetches nothing more and keeps all of its state until the next reset.

Top module: `accum_core`

## Requirements
- R1: A rising clock edge with `rst_n` low clears the program counter, the accumulator and `halted`. The first cycle after release presents address 0 on `mem_addr` with `mem_we` low.
- R2: Bits [9:7] of a memory word hold the opcode, bit 6 holds the mode flag and bits [5:0] hold the operand field. Bits above 9 are ignored. A mode flag of 1 takes the field as a literal, zero-extended to 16 bits. A mode flag of 0 takes it as a memory address.
- R3: Opcode 001 copies the operand value into the accumulator. Opcode 011 adds the operand value to the accumulator and opcode 100 subtracts it. Both wrap modulo 2^16 in two's complement.
- R4: Opcode 010 with mode 0 writes the accumulator to the field address with a single one-cycle `mem_we` pulse. Opcode 010 with mode 1, and opcode 000 in either mode, leave memory and the accumulator unchanged and only advance to the next instruction.
- R5: Opcode 101 compares the operand value with the accumulator. On a match, exactly one following instruction is skipped. Otherwise execution continues with the next instruction.
- R6: Opcode 110 continues execution at the address in the operand field, whatever the mode flag, without reading memory for the target.
- R7: Opcode 111 raises `halted`. From then on `mem_we` stays low and memory, the accumulator and the program counter keep their values until reset.
- R8: An instruction that reads its operand from memory (opcodes 001, 011, 100 or 101 with mode 0) takes 5 clock cycles. Every other instruction takes 4, and for the halt instruction this is counted up to the edge that raises `halted`.
- R9: A program that stores literal 2 at location 13 and literal 5 at location 14, loads location 13, adds location 14 and stores to location 15 leaves 7 in location 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | ADDR_W (6) | Word address for the current memory access |
| mem_wdata | output | DATA_W (16) | Accumulator value offered for a store |
| mem_we | output | 1 | Write strobe, high for one cycle per store |
| mem_rdata | input | DATA_W (16) | Registered read data for the address given one cycle earlier |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench uses the default DATA_W of 16 and ADDR_W of 6. This makes the whole 64-word address space small enough for the bench to hold and compare word for word after each program. It also puts the 0xFFFF to 0x0000 carry wrap and the 0x8000 borrow boundary within reach of single instructions. The largest literal, 63, exercises zero extension into a 16-bit value. Every program is also run through an instruction-level model kept in the bench. The model predicts both the final memory image and the exact cycle count up to `halted`, so the length of the wait phase is checked together with the results.

// File: rtl/acc_pkg.sv
// acc_pkg: phase and opcode encodings shared by the accumulator core.
// Assumes a fixed 3-bit opcode; data and address widths are parameters elsewhere.
package acc_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_LOADIR = 3'd1,
        PH_DECODE = 3'd2,
        PH_MWAIT  = 3'd3,
        PH_EXEC   = 3'd4,
        PH_HALT   = 3'd5
    } phase_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_ADD   = 3'd3,
        OP_SUB   = 3'd4,
        OP_EQUAL = 3'd5,
        OP_JUMP  = 3'd6,
        OP_HALT  = 3'd7
    } opcode_t;

    // True when the instruction needs a value read from memory before execute.
    function automatic logic reads_memory(opcode_t op, logic imm);
        return !imm && (op == OP_LOAD || op == OP_ADD ||
                        op == OP_SUB  || op == OP_EQUAL);
    endfunction

endpackage

// File: rtl/acc_seq.sv
// acc_seq: phase sequencer for the accumulator core.
// Steps fetch, IR load, decode, optional memory wait and execute.
// Parks in PH_HALT after a halt instruction. Assumes op/imm come from
// an IR that is valid from PH_DECODE onward.
module acc_seq
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_t op,
    input  logic    imm,
    output phase_t  phase
);

    phase_t phase_nxt;

    // Next-phase selection.
    always_comb begin
        case (phase)
            PH_FETCH:  phase_nxt = PH_LOADIR;
            PH_LOADIR: phase_nxt = PH_DECODE;
            PH_DECODE: phase_nxt = reads_memory(op, imm) ? PH_MWAIT : PH_EXEC;
            PH_MWAIT:  phase_nxt = PH_EXEC;
            PH_EXEC:   phase_nxt = (op == OP_HALT) ? PH_HALT : PH_FETCH;
            PH_HALT:   phase_nxt = PH_HALT;
            default:   phase_nxt = PH_FETCH;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nxt;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_HALT |=> phase == PH_HALT);  // R7
    AST_FETCH_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> phase == PH_LOADIR);  // R8
    AST_WAIT_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_MWAIT |-> $past(phase) == PH_DECODE);  // R8

endmodule

// File: rtl/acc_alu.sv
// acc_alu: combinational accumulator arithmetic and equality compare.
// Assumes two's complement operands of DATA_W bits; sums wrap.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_t           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic              acc_load,
    output logic [DATA_W-1:0] acc_res,
    output logic              match
);

    // Result and write enable for the accumulator.
    always_comb begin
        acc_load = 1'b1;
        case (op)
            OP_LOAD: acc_res = opnd;
            OP_ADD:  acc_res = acc + opnd;
            OP_SUB:  acc_res = acc - opnd;
            default: begin
                acc_res  = acc;
                acc_load = 1'b0;
            end
        endcase
    end

    // Equality used by the skip instruction.
    assign match = (acc == opnd);

endmodule

// File: rtl/acc_regs.sv
// acc_regs: program counter, instruction, accumulator and operand registers.
// Each register updates only in its own phase. Assumes mem_rdata holds the
// word addressed in the previous cycle.
module acc_regs
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  opcode_t           op,
    input  logic              imm,
    input  logic [ADDR_W-1:0] field,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              acc_load,
    input  logic [DATA_W-1:0] acc_res,
    input  logic              match,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W+3:0] ir,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] opnd
);

    localparam int INSN_W = ADDR_W + 4;
    localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Phase-directed register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= '0;
            ir   <= '0;
            acc  <= '0;
            opnd <= '0;
        end else begin
            case (phase)
                PH_LOADIR: begin
                    ir <= mem_rdata[INSN_W-1:0];
                    pc <= pc + PC_ONE;
                end
                PH_DECODE: begin
                    if (!reads_memory(op, imm))
                        opnd <= {{(DATA_W-ADDR_W){1'b0}}, field};
                end
                PH_MWAIT: opnd <= mem_rdata;
                PH_EXEC: begin
                    if (acc_load)
                        acc <= acc_res;
                    if (op == OP_EQUAL && match)
                        pc <= pc + PC_ONE;
                    else if (op == OP_JUMP)
                        pc <= field;
                end
                default: ;
            endcase
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_LOADIR |=> pc == $past(pc) + PC_ONE);  // R8
    AST_SKIP_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && op == OP_EQUAL && match) |=> pc == $past(pc) + PC_ONE);  // R5
    AST_ACC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        phase != PH_EXEC |=> $stable(acc));  // R3

endmodule

// File: rtl/accum_core.sv
// accum_core: multicycle accumulator processor with a synchronous memory port.
// Instruction layout in a word: opcode [ADDR_W+3:ADDR_W+1], mode [ADDR_W],
// field [ADDR_W-1:0]. Assumes one cycle of read latency on mem_rdata and
// DATA_W >= ADDR_W + 4.
module accum_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    localparam int INSN_W = ADDR_W + 4;

    phase_t            phase;
    opcode_t           op;
    logic              imm;
    logic [ADDR_W-1:0] field;
    logic [ADDR_W-1:0] pc;
    logic [INSN_W-1:0] ir;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] opnd;
    logic              acc_load;
    logic [DATA_W-1:0] acc_res;
    logic              match;

    // Instruction field split.
    assign op    = opcode_t'(ir[INSN_W-1:ADDR_W+1]);
    assign imm   = ir[ADDR_W];
    assign field = ir[ADDR_W-1:0];

    acc_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .imm   (imm),
        .phase (phase)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op),
        .acc      (acc),
        .opnd     (opnd),
        .acc_load (acc_load),
        .acc_res  (acc_res),
        .match    (match)
    );

    acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .op        (op),
        .imm       (imm),
        .field     (field),
        .mem_rdata (mem_rdata),
        .acc_load  (acc_load),
        .acc_res   (acc_res),
        .match     (match),
        .pc        (pc),
        .ir        (ir),
        .acc       (acc),
        .opnd      (opnd)
    );

    // Memory port: fetch at PC, otherwise at the operand field.
    assign mem_addr  = (phase == PH_FETCH) ? pc : field;
    assign mem_wdata = acc;
    assign mem_we    = (phase == PH_EXEC) && (op == OP_STORE) && !imm;
    assign halted    = (phase == PH_HALT);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && acc == '0 && !halted));  // R1
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);  // R4
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);  // R7
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(acc)));  // R7

endmodule

// File: tb/accum_core_test.sv
// Bench for accum_core: vector table of one-instruction programs, then
// directed programs for reset, literals, jumps and halt. Each program is
// also run on an instruction-level model to predict memory and cycles.
module accum_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 64;

    // op, x (mem 60), y (mem 61), expected word at 62
    localparam logic [50:0] VEC [8] = '{
        {3'd3, 16'h00A1, 16'h00FE, 16'h019F},
        {3'd3, 16'hFFFF, 16'h0002, 16'h0001},
        {3'd4, 16'h0005, 16'h0009, 16'hFFFC},
        {3'd4, 16'h8000, 16'h0001, 16'h7FFF},
        {3'd5, 16'h0014, 16'h0014, 16'hDEAD},
        {3'd5, 16'h0014, 16'h0015, 16'h0014},
        {3'd1, 16'h1234, 16'hABCD, 16'hABCD},
        {3'd0, 16'h0BEE, 16'h0777, 16'h0BEE}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              halted;

    logic [DATA_W-1:0] mem     [DEPTH];
    logic [DATA_W-1:0] img     [DEPTH];
    logic [DATA_W-1:0] ref_mem [DEPTH];
    logic [DATA_W-1:0] snap    [DEPTH];
    logic              load_img = 1'b0;
    int                ref_cycles;
    int                n_checks = 0;
    int                n_errors = 0;

    accum_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous memory model with one cycle of read latency.
    always @(posedge clk) begin
        if (load_img) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [15:0] ins(logic [2:0] op, logic md, logic [5:0] f);
        return {6'b0, op, md, f};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_img(input logic [15:0] fill);
        for (int i = 0; i < DEPTH; i++) img[i] = fill;
    endtask

    // Instruction-level model: final memory in ref_mem, cycles in ref_cycles.
    task automatic model_run();
        logic [5:0]  p;
        logic [15:0] a, w, v;
        logic [2:0]  o;
        logic        md;
        logic [5:0]  f;
        p = '0;
        a = '0;
        ref_cycles = 0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = img[i];
        for (int s = 0; s < 2000; s++) begin
            w  = ref_mem[p];
            o  = w[9:7];
            md = w[6];
            f  = w[5:0];
            p  = p + 6'd1;
            v  = md ? {10'b0, f} : ref_mem[f];
            ref_cycles += (!md && (o == 3'd1 || o == 3'd3 || o == 3'd4 || o == 3'd5)) ? 5 : 4;
            if (o == 3'd7) break;
            case (o)
                3'd1: a = v;
                3'd2: if (!md) ref_mem[f] = a;
                3'd3: a = a + v;
                3'd4: a = a - v;
                3'd5: if (a == v) p = p + 6'd1;
                3'd6: p = f;
                default: ;
            endcase
        end
    endtask

    // Load image under reset, release, and count edges until halted.
    task automatic run_dut(input bit chk_reset, output int cyc, output bit ok);
        @(negedge clk);
        rst_n    = 1'b0;
        load_img = 1'b1;
        @(negedge clk);
        load_img = 1'b0;
        if (chk_reset) begin
            check("R1", "halted in reset", {31'b0, halted}, 32'd0);
            check("R1", "mem_we in reset", {31'b0, mem_we}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        if (chk_reset) begin
            check("R1", "first fetch address", {26'b0, mem_addr}, 32'd0);
            check("R1", "mem_we after release", {31'b0, mem_we}, 32'd0);
        end
        cyc = 0;
        ok  = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) begin
                ok = 1'b1;
                break;
            end
        end
        check("R7", "halted reached", {31'b0, ok}, 32'd1);
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== ref_mem[i]) bad++;
        check(req, what, bad, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int  cyc;
        bit  ok;
        int  we_seen;
        int  lost;
        int  bad;
        string tag;

        // R9 and R1: the sample addition program, with reset checks.
        clear_img(16'h0000);
        img[0] = ins(3'd1, 1'b1, 6'd2);
        img[1] = ins(3'd2, 1'b0, 6'd13);
        img[2] = ins(3'd1, 1'b1, 6'd5);
        img[3] = ins(3'd2, 1'b0, 6'd14);
        img[4] = ins(3'd1, 1'b0, 6'd13);
        img[5] = ins(3'd3, 1'b0, 6'd14);
        img[6] = ins(3'd2, 1'b0, 6'd15);
        img[7] = ins(3'd7, 1'b0, 6'd0);
        model_run();
        run_dut(1'b1, cyc, ok);
        check("R9", "location 15", {16'b0, mem[15]}, 32'd7);
        check("R9", "location 13", {16'b0, mem[13]}, 32'd2);
        check("R8", "sample cycles", cyc, ref_cycles);

        // Vector table: one operation between two memory operands.
        for (int t = 0; t < 8; t++) begin
            logic [2:0]  vop;
            logic [15:0] vx, vy, vexp;
            {vop, vx, vy, vexp} = VEC[t];
            clear_img(16'h0000);
            img[0]  = ins(3'd1, 1'b0, 6'd60);
            img[1]  = ins(vop,  1'b0, 6'd61);
            img[2]  = ins(3'd2, 1'b0, 6'd62);
            img[3]  = ins(3'd1, 1'b1, 6'd1);
            img[4]  = ins(3'd2, 1'b0, 6'd63);
            img[5]  = ins(3'd7, 1'b0, 6'd0);
            img[60] = vx;
            img[61] = vy;
            img[62] = 16'hDEAD;
            case (vop)
                3'd5:    tag = "R5";
                3'd0:    tag = "R4";
                default: tag = "R3";
            endcase
            model_run();
            run_dut(1'b0, cyc, ok);
            check(tag, $sformatf("vector %0d result", t), {16'b0, mem[62]}, {16'b0, vexp});
            check(tag, $sformatf("vector %0d marker", t), {16'b0, mem[63]}, 32'd1);
            compare_mem(tag, $sformatf("vector %0d memory mismatches", t));
            check("R8", $sformatf("vector %0d cycles", t), cyc, ref_cycles);
        end

        // R2, R4, R6: literals, ignored upper bits, immediate store, jumps.
        clear_img(16'h0000);
        img[0]  = ins(3'd1, 1'b1, 6'd63);
        img[1]  = 16'hFC00 | ins(3'd3, 1'b1, 6'd1);
        img[2]  = ins(3'd2, 1'b1, 6'd50);
        img[3]  = ins(3'd6, 1'b0, 6'd6);
        img[4]  = ins(3'd2, 1'b0, 6'd40);
        img[5]  = ins(3'd2, 1'b0, 6'd40);
        img[6]  = ins(3'd2, 1'b0, 6'd41);
        img[7]  = ins(3'd6, 1'b1, 6'd9);
        img[8]  = ins(3'd2, 1'b0, 6'd42);
        img[9]  = ins(3'd2, 1'b0, 6'd43);
        img[10] = ins(3'd7, 1'b0, 6'd0);
        img[11] = ins(3'd2, 1'b0, 6'd44);
        img[50] = 16'hBEEF;
        model_run();
        run_dut(1'b0, cyc, ok);
        check("R2", "literal 63 plus 1 zero-extended", {16'b0, mem[41]}, 32'h40);
        check("R4", "immediate store leaves 50", {16'b0, mem[50]}, 32'hBEEF);
        check("R6", "direct jump skipped 40", {16'b0, mem[40]}, 32'd0);
        check("R6", "literal jump skipped 42", {16'b0, mem[42]}, 32'd0);
        check("R6", "jump target stored 43", {16'b0, mem[43]}, 32'h40);
        check("R8", "literal program cycles", cyc, 32'd32);
        compare_mem("R6", "jump program memory mismatches");

        // R7: halted core holds for many cycles.
        for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
        we_seen = 0;
        lost = 0;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (mem_we) we_seen++;
            if (!halted) lost++;
        end
        check("R7", "writes after halt", we_seen, 32'd0);
        check("R7", "halted dropped", lost, 32'd0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== snap[i]) bad++;
        check("R7", "memory changed after halt", bad, 32'd0);
        check("R7", "instruction after halt not run", {16'b0, mem[44]}, 32'd0);

        // R1: reset after halt clears the accumulator and halted.
        clear_img(16'h0000);
        img[0]  = ins(3'd2, 1'b0, 6'd45);
        img[1]  = ins(3'd7, 1'b0, 6'd0);
        img[45] = 16'hFFFF;
        model_run();
        run_dut(1'b1, cyc, ok);
        check("R1", "accumulator cleared by reset", {16'b0, mem[45]}, 32'd0);
        check("R8", "store then halt cycles", cyc, 32'd8);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule